// File: doc/BRIEF.md
# Gated Decimal Frequency Meter

This block measures the frequency of an external square wave by counting its rising edges over a fixed gate window. The gate is made inside the block from the system clock. It stays closed for one window length, then open for one window length, and repeats. While the gate is open, each rising edge of the measured signal advances a chain of decimal (BCD) digit counters. When the gate closes, the count is copied into output registers and held there until the next window closes. The counters are then cleared for the rest of the closed half.

With the default window of 50,000,000 cycles of a 50 MHz clock, the held value is the input frequency in hertz. The measured input is resynchronised to the system clock, so no logic is clocked by the external signal. The block also produces leading-zero blank flags for a display and an overflow flag for inputs beyond the counter range. The gate level is brought out so it can drive a monitor LED.

Top module: `freq_meter`

## Requirements
- R1: After reset the gate output is low, every result digit is 0, the overflow flag is 0, and the blank flags are set for every digit except digit 0.
- R2: The gate output alternates between GATE_CYCLES clock cycles low and GATE_CYCLES clock cycles high, starting with the low half after reset.
- R3: While the gate is high, each rising edge of the measured input adds one to the count. Each input level must last at least one clock cycle. Edges arriving while the gate is low have no effect on the result.
- R4: The result outputs take the window's count once, just after the gate falls. They then hold that value unchanged through the following low and high halves.
- R5: Each window starts counting from zero, so a result reflects only the edges of its own window.
- R6: The result holds DIGITS BCD digits. Digit i sits in bits [4i+3:4i], each digit is in the range 0 to 9, and a digit rolls from 9 to 0 with a carry into the next higher digit.
- R7: Blank flag bit i (for i ≥ 1) is 1 exactly when result digit i and every higher digit are 0. Blank flag bit 0 is always 0.
- R8: When a window has more edges than the largest value DIGITS digits can hold, the result is all nines. The overflow flag is set alongside it. Otherwise the overflow flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| measIn | input | 1 | Square wave being measured, asynchronous to clk |
| digitsOut | output | 4*DIGITS | Held BCD result, digit 0 in the lowest nibble |
| blankOut | output | DIGITS | Leading-zero blank flag per digit |
| overflowOut | output | 1 | Held result saturated at all nines |
| gateLed | output | 1 | Gate level, high while counting |

## Verification
The hardest condition to reach is a saturating overflow. With seven digits it needs ten million edges inside one window, which no short run can supply. The bench therefore drives a second, two-digit instance in parallel with the same input and the same gate length. Windows of 99, 100 and a few hundred edges then push that instance across its saturation point, while the seven-digit instance checks the exact count. Edges injected during the closed half confirm that they are ignored. Windows of 9, 10, 999 and 1000 edges exercise the carry chain and the change in leading-zero blanking.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;
  // Strobes passed from gate control to the counting datapath
  typedef struct packed {
    logic countEn;   // gate open: edges advance the counters
    logic latchNow;  // first closed cycle: copy counters to outputs
    logic clearNow;  // rest of closed half: hold counters at zero
  } gateStrobes_t;
endpackage

// File: rtl/fm_gate_ctrl.sv
module fm_gate_ctrl
  import freq_meter_pkg::*;
#(
  parameter int GATE_CYCLES = 50_000_000
) (
  input  logic         clk,
  input  logic         rstN,
  output gateStrobes_t strobes,
  output logic         gateOpen
);
  localparam int CW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(GATE_CYCLES - 1);

  logic [CW-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      gateOpen <= 1'b0;
    end else if (phaseCnt == LAST) begin
      phaseCnt <= '0;
      gateOpen <= ~gateOpen;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.countEn  = gateOpen;
    strobes.latchNow = !gateOpen && (phaseCnt == '0);
    strobes.clearNow = !gateOpen && (phaseCnt != '0);
  end

  // R2
  gate_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gateOpen != $past(gateOpen)) |-> ($past(phaseCnt) == LAST));
endmodule

// File: rtl/fm_count_path.sv
module fm_count_path
  import freq_meter_pkg::*;
#(
  parameter int DIGITS = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  measIn,
  input  gateStrobes_t          strobes,
  output logic [4*DIGITS-1:0]   digitsOut,
  output logic [DIGITS-1:0]     blankOut,
  output logic                  ovfOut
);
  localparam int W = 4 * DIGITS;
  localparam logic [DIGITS-1:0] BLANK_RST = {DIGITS{1'b1}} << 1;
  localparam logic [W-1:0] ALL_NINES = {DIGITS{4'h9}};

  // input synchroniser and rise detector
  logic [2:0] syncPipe;
  logic       riseSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[1:0], measIn};
  end
  assign riseSeen = syncPipe[1] & ~syncPipe[2];

  // decade counter chain
  logic [3:0]      cntDig [DIGITS];
  logic [DIGITS:0] carry;
  logic [W-1:0]    cntFlat;
  logic            ovfCnt;

  always_comb begin
    carry[0] = strobes.countEn & riseSeen;
    for (int i = 0; i < DIGITS; i++)
      carry[i+1] = carry[i] && (cntDig[i] == 4'd9);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DIGITS; i++) cntDig[i] <= '0;
      ovfCnt <= 1'b0;
    end else if (strobes.clearNow) begin
      for (int i = 0; i < DIGITS; i++) cntDig[i] <= '0;
      ovfCnt <= 1'b0;
    end else if (carry[DIGITS]) begin
      ovfCnt <= 1'b1;                    // saturate: digits stay at nine
    end else begin
      for (int i = 0; i < DIGITS; i++)
        if (carry[i])
          cntDig[i] <= (cntDig[i] == 4'd9) ? 4'd0 : cntDig[i] + 4'd1;
    end
  end

  // leading-zero detection on the live count
  logic [DIGITS:0] zeroFrom;
  assign zeroFrom[DIGITS] = 1'b1;
  assign zeroFrom[0]      = 1'b0;
  for (genvar g = 0; g < DIGITS; g++) begin : g_flat
    assign cntFlat[g*4 +: 4] = cntDig[g];
  end
  for (genvar g = 1; g < DIGITS; g++) begin : g_zero
    assign zeroFrom[g] = zeroFrom[g+1] && (cntDig[g] == 4'd0);
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      digitsOut <= '0;
      blankOut  <= BLANK_RST;
      ovfOut    <= 1'b0;
    end else if (strobes.latchNow) begin
      digitsOut <= cntFlat;
      blankOut  <= zeroFrom[DIGITS-1:0];
      ovfOut    <= ovfCnt;
    end
  end

  // R6
  for (genvar g = 0; g < DIGITS; g++) begin : g_rng
    digit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      digitsOut[g*4 +: 4] <= 4'd9);
  end

  // R5
  clear_before_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.countEn) |-> (cntFlat == '0) && !ovfCnt);

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchNow |=> $stable(digitsOut) && $stable(ovfOut));

  // R8
  saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfOut |-> (digitsOut == ALL_NINES));

  // R7
  blank_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !blankOut[0]);
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freq_meter_pkg::*;
#(
  parameter int GATE_CYCLES = 50_000_000,
  parameter int DIGITS      = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                measIn,
  output logic [4*DIGITS-1:0] digitsOut,
  output logic [DIGITS-1:0]   blankOut,
  output logic                overflowOut,
  output logic                gateLed
);
  gateStrobes_t strobes;

  fm_gate_ctrl #(.GATE_CYCLES(GATE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .gateOpen (gateLed)
  );

  fm_count_path #(.DIGITS(DIGITS)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .measIn    (measIn),
    .strobes   (strobes),
    .digitsOut (digitsOut),
    .blankOut  (blankOut),
    .ovfOut    (overflowOut)
  );
endmodule

// File: tb/freq_meter_bench.sv
module freq_meter_bench;
  localparam int GATE = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic measIn = 1'b0;
  logic [27:0] digits;
  logic [6:0]  blank;
  logic        ovf, gate;
  logic [7:0]  sDigits;
  logic [1:0]  sBlank;
  logic        sOvf, sGate;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  int prevN = 0;

  always #5 clk = ~clk;

  freq_meter #(.GATE_CYCLES(GATE), .DIGITS(7)) u_freq_meter (
    .clk(clk), .rstN(rstN), .measIn(measIn), .digitsOut(digits),
    .blankOut(blank), .overflowOut(ovf), .gateLed(gate));

  freq_meter #(.GATE_CYCLES(GATE), .DIGITS(2)) u_small (
    .clk(clk), .rstN(rstN), .measIn(measIn), .digitsOut(sDigits),
    .blankOut(sBlank), .overflowOut(sOvf), .gateLed(sGate));

  function automatic logic [27:0] bcdOf(int n);
    logic [27:0] r;
    int v = n;
    for (int i = 0; i < 7; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic logic [6:0] blankOf(int n, int d);
    logic [6:0] b = '0;
    int lim = 10;
    for (int i = 1; i < d; i++) begin
      b[i] = (n < lim);
      lim = lim * 10;
    end
    return b;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // R2: measure gate run lengths after the first low half
  int runLen = 0;
  int runsChecked = 0;
  logic lastGate = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (gate !== lastGate) begin
        if (runsChecked > 0 && runsChecked < 5)
          chk(runLen == GATE, "R2", "gate half length", runLen, GATE);
        runsChecked++;
        runLen = 1;
        lastGate = gate;
      end else begin
        runLen++;
      end
    end
  end

  task automatic runWindow(int target, int half, bit noise);
    int el, n, smallExp;
    while (gate !== 1'b1) @(negedge clk);
    // R4: previous result still held into the next open half
    chk(digits == bcdOf(prevN), "R4", "held result", digits, bcdOf(prevN));
    repeat (4) @(negedge clk);
    el = 4;
    n = 0;
    while (n < target && el + 2*half < GATE - 10) begin
      measIn = 1'b1; repeat (half) @(negedge clk);
      measIn = 1'b0; repeat (half) @(negedge clk);
      el += 2*half;
      n++;
    end
    while (gate === 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
    // R3 R5 R6: exact count of this window
    chk(digits == bcdOf(n), "R3", "count digits", digits, bcdOf(n));
    // R7
    chk(blank == blankOf(n, 7), "R7", "blank flags", blank, blankOf(n, 7));
    chk(ovf == 1'b0, "R8", "wide overflow", ovf, 0);
    smallExp = (n > 99) ? 99 : n;
    // R8: two-digit instance saturates
    chk(sDigits == bcdOf(smallExp)[7:0], "R8", "small digits", sDigits, bcdOf(smallExp)[7:0]);
    chk(sOvf == (n > 99), "R8", "small overflow", sOvf, (n > 99));
    chk(sBlank == blankOf(smallExp, 2)[1:0], "R7", "small blank", sBlank, blankOf(smallExp, 2)[1:0]);
    prevN = n;
    if (noise) begin
      // R3: edges during the closed half must not count
      el = 5;
      while (el + 4 < GATE - 10) begin
        measIn = 1'b1; repeat (2) @(negedge clk);
        measIn = 1'b0; repeat (2) @(negedge clk);
        el += 4;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(gate == 1'b0, "R1", "gate", gate, 0);
    chk(digits == '0, "R1", "digits", digits, 0);
    chk(ovf == 1'b0, "R1", "overflow", ovf, 0);
    chk(blank == 7'b1111110, "R1", "blank", blank, 7'b1111110);
    rstN = 1'b1;
    @(negedge clk);
    runWindow(0, 1, 1'b0);
    runWindow(1, 2, 1'b1);
    runWindow(9, 2, 1'b0);    // R6 single digit top
    runWindow(10, 1, 1'b1);   // R6 first carry
    runWindow(99, 1, 1'b0);
    runWindow(100, 1, 1'b1);  // R8 small instance saturates
    runWindow(999, 1, 1'b0);
    runWindow(1000, 1, 1'b1);
    runWindow(100000, 1, 1'b1); // maximum rate
    for (int k = 0; k < 5; k++)
      runWindow(int'($urandom_range(1400, 0)), int'($urandom_range(2, 1)), 1'($urandom_range(1, 0)));
    finishRun();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule